// File: doc/BRIEF.md
# DMA Completion Interrupt Control Register

This block is the interrupt control register that sits between a set of DMA channels and the system interrupt controller. It is one 32-bit register. Software writes it to choose which channels may raise an interrupt, to turn on the master enable, to force an interrupt through the bus-error bit, and to clear completion flags. Each channel reports the end of a transfer with a one-cycle completion strobe. If that channel is enabled, the strobe sets a sticky flag.

A summary bit is worked out again whenever the register state changes. It is true when the master enable is on and any flag is set, or when the bus-error bit is on. The system interrupt controller takes a single-cycle request pulse on its DMA input, bit 3. That pulse fires only when the summary bit goes from clear to set. More flags arriving while the summary bit is already set raise no further request. Software has to clear the flags (or turn off the master enable or the bus-error bit) so that the summary bit drops before a new request can fire.

Top module: `dma_irq_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, the read-back value is 0x00000000 and no request pulse is present.
- R2: A write stores bits 0-5 (spare field), bit 15 (bus-error force), bits 16-22 (channel n enable at bit 16+n) and bit 23 (master enable) straight from the written value. Bits 6-14 always read back as 0.
- R3: A write clears each flag at bit 24+n for which the written value has a 1 at bit 24+n. Flags whose written bit is 0 keep their value.
- R4: A completion strobe on channel n sets flag bit 24+n only if enable bit 16+n was already set before that cycle. No flag is set in any other way.
- R5: When a completion strobe that is allowed to set flag n arrives in the same cycle as a write that clears flag n, the flag ends up set.
- R6: After every update, bit 31 reads 1 exactly when (bit 23 is set and any of bits 24-30 is set) or bit 15 is set. Otherwise it reads 0.
- R7: The request pulse goes high for exactly one cycle, and it does so in the same cycle that bit 31 goes from 0 to 1.
- R8: New flags set while bit 31 is already 1 produce no request pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Value written to the register |
| done_strobe | input | NUM_CH | Per-channel transfer-complete strobes, bit n for channel n |
| rd_data | output | 32 | Current register value |
| irq_pulse | output | 1 | One-cycle request to the interrupt controller's DMA source |

## Verification
A write or strobe that is presented before a rising edge changes both rd_data and irq_pulse right after that same edge. Each result therefore lags its stimulus by exactly one cycle. The bench drives inputs on the falling edge and samples both outputs on the next falling edge, one full cycle later. Before that edge it compares them with a value it has computed from the requirements. Idle cycles after each pulse confirm that the pulse has dropped and that nothing moved without a stimulus.

// File: rtl/dicr_pkg.sv
package dicr_pkg;

    localparam int MAX_CH     = 7;
    localparam int REG_W      = 32;
    localparam int AUX_W      = 6;
    localparam int FORCE_POS  = 15;
    localparam int EN_POS     = 16;
    localparam int MASTER_POS = EN_POS + MAX_CH;
    localparam int FLAG_POS   = MASTER_POS + 1;
    localparam int SENT_POS   = FLAG_POS + MAX_CH;

    typedef struct packed {
        logic [AUX_W-1:0]  aux;
        logic              force_err;
        logic [MAX_CH-1:0] en;
        logic              master;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [MAX_CH-1:0] flags;
        logic              sent;
        logic              irq;
    } state_t;

    function automatic logic [REG_W-1:0] pack_reg(input state_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[AUX_W-1:0]                  = s.ctrl.aux;
        r[FORCE_POS]                  = s.ctrl.force_err;
        r[EN_POS +: MAX_CH]           = s.ctrl.en;
        r[MASTER_POS]                 = s.ctrl.master;
        r[FLAG_POS +: MAX_CH]         = s.flags;
        r[SENT_POS]                   = s.sent;
        return r;
    endfunction

endpackage

// File: rtl/dicr_wr_decode.sv
module dicr_wr_decode
    import dicr_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic [REG_W-1:0]  wr_data,
    output ctrl_t             wr_ctrl,
    output logic [MAX_CH-1:0] clr_mask
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[FORCE_POS-1:AUX_W], wr_data[SENT_POS]};

    always_comb begin
        wr_ctrl           = '0;
        clr_mask          = '0;
        wr_ctrl.aux       = wr_data[AUX_W-1:0];
        wr_ctrl.force_err = wr_data[FORCE_POS];
        wr_ctrl.master    = wr_data[MASTER_POS];
        for (int i = 0; i < NUM_CH; i++) begin
            wr_ctrl.en[i] = wr_data[EN_POS + i];
            clr_mask[i]   = wr_data[FLAG_POS + i];
        end
    end

endmodule

// File: rtl/dicr_flag_bank.sv
module dicr_flag_bank
    import dicr_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic [MAX_CH-1:0] flags_q,
    input  logic [MAX_CH-1:0] en_q,
    input  logic [NUM_CH-1:0] done_strobe,
    input  logic              wr_en,
    input  logic [MAX_CH-1:0] clr_mask,
    output logic [MAX_CH-1:0] flags_d
);

    genvar g;
    generate
        for (g = 0; g < MAX_CH; g++) begin : g_flag
            if (g < NUM_CH) begin : g_live
                logic set_hit;
                logic clr_hit;
                assign set_hit    = done_strobe[g] & en_q[g];
                assign clr_hit    = wr_en & clr_mask[g];
                // a completion in the same cycle outranks the clear
                assign flags_d[g] = set_hit | (flags_q[g] & ~clr_hit);
            end else begin : g_tied
                logic unused_flag;
                assign unused_flag = ^{flags_q[g], en_q[g], clr_mask[g]};
                assign flags_d[g]  = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/dicr_summary.sv
module dicr_summary
    import dicr_pkg::*;
(
    input  ctrl_t             ctrl_d,
    input  logic [MAX_CH-1:0] flags_d,
    input  logic              sent_q,
    output logic              sent_d,
    output logic              irq_d
);

    always_comb begin
        sent_d = (ctrl_d.master & (|flags_d)) | ctrl_d.force_err;
        irq_d  = sent_d & ~sent_q;
    end

endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
    import dicr_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [NUM_CH-1:0] done_strobe,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_pulse
);

    state_t            st_q;
    state_t            st_d;
    ctrl_t             wr_ctrl;
    ctrl_t             ctrl_d;
    logic [MAX_CH-1:0] clr_mask;
    logic [MAX_CH-1:0] flags_d;
    logic              sent_d;
    logic              irq_d;

    dicr_wr_decode #(.NUM_CH(NUM_CH)) u_decode (
        .wr_data  (wr_data),
        .wr_ctrl  (wr_ctrl),
        .clr_mask (clr_mask)
    );

    assign ctrl_d = wr_en ? wr_ctrl : st_q.ctrl;

    dicr_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
        .flags_q     (st_q.flags),
        .en_q        (st_q.ctrl.en),
        .done_strobe (done_strobe),
        .wr_en       (wr_en),
        .clr_mask    (clr_mask),
        .flags_d     (flags_d)
    );

    dicr_summary u_summary (
        .ctrl_d  (ctrl_d),
        .flags_d (flags_d),
        .sent_q  (st_q.sent),
        .sent_d  (sent_d),
        .irq_d   (irq_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ctrl  = ctrl_d;
        st_d.flags = flags_d;
        st_d.sent  = sent_d;
        st_d.irq   = irq_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = pack_reg(st_q);
    assign irq_pulse = st_q.irq;

    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[FORCE_POS-1:AUX_W] == '0); // R2

    AST_SENT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[SENT_POS] == ((rd_data[MASTER_POS] && (|rd_data[FLAG_POS +: MAX_CH]))
                              || rd_data[FORCE_POS])); // R6

    AST_PULSE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (rd_data[SENT_POS] && !$past(rd_data[SENT_POS]))); // R7

    AST_EDGE_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[SENT_POS]) |-> irq_pulse); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R8

    genvar a;
    generate
        for (a = 0; a < NUM_CH; a++) begin : g_chk
            AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rd_data[FLAG_POS + a]) |-> $past(done_strobe[a] && rd_data[EN_POS + a])); // R4

            AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                (done_strobe[a] && rd_data[EN_POS + a]) |=> rd_data[FLAG_POS + a]); // R5

            AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data[FLAG_POS + a] && !(done_strobe[a] && rd_data[EN_POS + a]))
                |=> !rd_data[FLAG_POS + a]); // R3
        end
    endgenerate

endmodule

// File: tb/dma_irq_ctl_test.sv
`timescale 1ns/1ps
module dma_irq_ctl_test;

    localparam int NCH = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [NCH-1:0]  done_strobe = '0;
    logic [31:0]     rd_data;
    logic            irq_pulse;

    int errors = 0;
    int checks = 0;
    logic [31:0] model = '0;

    always #2.5 clk = ~clk;

    dma_irq_ctl #(.NUM_CH(NCH)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .done_strobe (done_strobe),
        .rd_data     (rd_data),
        .irq_pulse   (irq_pulse)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, got, exp);
        end
    endtask

    // one cycle: inputs held over a rising edge, results checked one cycle later
    task automatic step(input logic wr, input logic [31:0] wd,
                        input logic [NCH-1:0] dn, input string tag);
        logic [31:0] nxt;
        logic [6:0]  fl;
        logic        exp_irq;
        wr_en = wr; wr_data = wd; done_strobe = dn;
        nxt = model;
        fl  = model[30:24];
        if (wr) begin
            nxt[5:0]   = wd[5:0];
            nxt[14:6]  = '0;
            nxt[15]    = wd[15];
            nxt[23:16] = wd[23:16];
            fl         = fl & ~wd[30:24];
        end
        fl = fl | (dn & model[22:16]);
        nxt[30:24] = fl;
        nxt[31] = (nxt[23] && (|fl)) || nxt[15];
        exp_irq = nxt[31] && !model[31];
        model = nxt;
        @(negedge clk);
        chk(tag, "rd_data", rd_data, model);
        chk(tag, "irq_pulse", {31'b0, irq_pulse}, {31'b0, exp_irq});
        wr_en = 1'b0; wr_data = '0; done_strobe = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "rd_data in reset", rd_data, 32'h0);
        chk("R1", "irq in reset", {31'b0, irq_pulse}, 32'h0);
        rst_n = 1'b1;
        step(1'b0, 32'h0, '0, "R1");

        // every storable field at once; force bit raises the summary
        step(1'b1, 32'hFFFF_FFFF, '0, "R2");
        step(1'b0, 32'h0, '0, "R7");
        for (int k = 0; k < 8; k++)
            step(1'b1, 32'hA5A5_5A5A ^ (k * 32'h1111_1111), '0, "R2");
        step(1'b1, 32'h7F00_0000, '0, "R6");

        // sweep every channel against its enable and the master enable
        for (int n = 0; n < NCH; n++) begin
            for (int en = 0; en < 2; en++) begin
                for (int ms = 0; ms < 2; ms++) begin
                    logic [31:0] base;
                    base = (32'(en) << (16 + n)) | (32'(ms) << 23);
                    step(1'b1, base | 32'h7F00_0000, '0, "R3");
                    step(1'b0, 32'h0, NCH'(1) << n, "R4");
                    step(1'b0, 32'h0, NCH'(1) << n, "R8");
                    step(1'b1, base | (32'h1 << (24 + n)), '0, "R3");
                end
            end
        end

        // strobe and clear of the same flag in one cycle
        step(1'b1, 32'h00FF_0000, '0, "R2");
        for (int n = 0; n < NCH; n++) begin
            step(1'b1, 32'h00FF_0000 | (32'h1 << (24 + n)), NCH'(1) << n, "R5");
            step(1'b1, 32'h7FFF_0000, NCH'(1) << n, "R5");
            step(1'b1, 32'h7FFF_0000, '0, "R3");
        end

        // selective clearing
        step(1'b0, 32'h0, 7'h7F, "R4");
        step(1'b1, 32'h55FF_0000, '0, "R3");
        step(1'b1, 32'h2AFF_0000, '0, "R6");

        // bus-error force alone
        step(1'b1, 32'h0000_8000, '0, "R6");
        step(1'b1, 32'h0080_8000, 7'h7F, "R4");
        step(1'b1, 32'h0, '0, "R6");
        step(1'b1, 32'h0000_8000, '0, "R7");
        step(1'b0, 32'h0, '0, "R7");

        // flags pending with master off, then master on
        step(1'b1, 32'h007F_0000, '0, "R6");
        step(1'b0, 32'h0, 7'h7F, "R6");
        step(1'b1, 32'h00FF_0000, '0, "R7");
        step(1'b0, 32'h0, 7'h01, "R8");
        step(1'b1, 32'h7F7F_0000, '0, "R6");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule